// File: doc/BRIEF.md
# Atomic Exchange and Fetch-Add Unit

This block performs one indivisible read-modify-write on a single-port synchronous word memory. Lock primitives use it. A request names the operation, the source register, two address registers and a signed displacement. The unit adds the displacement and the two register values to form the word address. It then either swaps the source register with the memory word (exchange) or adds the source register into the memory word (fetch-add). In both cases the memory word that was there before goes back into the source register.

The register file lies outside the block. The unit drives three combinational read-address ports and one write port. Index 0 is a hidden register that always reads zero, so a request fills an unused address term by naming index 0. Every index at or above the register count also reads as zero. While the read and the write are in progress the unit holds a lock output, so that no other agent can reach the memory between them.

Top module: `rmw_lock_unit`

## Requirements
- R1: The memory word address is the low AW bits of the 32-bit wrap-around sum of disp + value(base A) + value(base B).
- R2: Register index 0, and any index at or above NREGS (7), supplies the value zero whatever the register file returns for it.
- R3: Exchange (op = 0) writes the source value into the addressed word and writes the old word into the source register.
- R4: Fetch-add (op = 1) writes old word + source value, modulo 2^32, into the addressed word and writes the old word into the source register.
- R5: When the source index is 0 or at or above NREGS, no register write is issued. The memory write still takes place.
- R6: A request is legal only with src_kind = 0 (register) and dst_kind = 2 (memory). For any other pairing, reject is high for exactly the one cycle after start, and no memory or register access takes place.
- R7: After an accepted start, the first busy cycle issues the memory read. The second busy cycle issues the memory write, the register writeback and a one-cycle done. Busy then falls. Lock is high in both cycles and the address is the same in both.
- R8: A start that arrives while busy is ignored.
- R9: After reset, busy, done, lock, mem_en, mem_we, rf_we and reject are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| op | input | 1 | 0 exchange, 1 fetch-add |
| src_kind | input | 2 | Source operand kind (0 register, 1 immediate, 2 memory, 3 label) |
| dst_kind | input | 2 | Destination operand kind, same coding |
| src_idx | input | RIW | Source register index |
| base_a_idx | input | RIW | First address register index |
| base_b_idx | input | RIW | Second address register index |
| disp | input | DW | Signed displacement |
| rf_raddr_s | output | RIW | Register read address for the source |
| rf_raddr_a | output | RIW | Register read address for base A |
| rf_raddr_b | output | RIW | Register read address for base B |
| rf_rdata_s | input | DW | Source register data |
| rf_rdata_a | input | DW | Base A register data |
| rf_rdata_b | input | DW | Base B register data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RIW | Register write index |
| rf_wdata | output | DW | Register write data (old memory word) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| lock | output | 1 | Held across the read and the write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at register writeback |
| reject | output | 1 | One-cycle pulse for an illegal operand pairing |

## Verification
Two situations are the hardest to reach: a start that lands in the middle of an operation, and a source register that is also an address term. The second is hard because the writeback changes a value that the address depended on. The directed cases drive a second start with a different operation and address during the read cycle. They also issue requests whose source is one of the base registers, with the hidden-zero entry of the modelled register file holding a nonzero value. The random phase mixes both operations, all register indices including 0 and 7, negative displacements, sums that wrap, and illegal operand kinds.

// File: rtl/rmw_lock_unit.sv
module rmw_lock_unit #(
  parameter int DW    = 32,
  parameter int AW    = 10,
  parameter int RIW   = 3,
  parameter int NREGS = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           op,
  input  logic [1:0]     src_kind,
  input  logic [1:0]     dst_kind,
  input  logic [RIW-1:0] src_idx,
  input  logic [RIW-1:0] base_a_idx,
  input  logic [RIW-1:0] base_b_idx,
  input  logic [DW-1:0]  disp,
  output logic [RIW-1:0] rf_raddr_s,
  output logic [RIW-1:0] rf_raddr_a,
  output logic [RIW-1:0] rf_raddr_b,
  input  logic [DW-1:0]  rf_rdata_s,
  input  logic [DW-1:0]  rf_rdata_a,
  input  logic [DW-1:0]  rf_rdata_b,
  output logic           rf_we,
  output logic [RIW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           lock,
  output logic           busy,
  output logic           done,
  output logic           reject
);
  localparam logic [1:0] KIND_REG = 2'd0;
  localparam logic [1:0] KIND_MEM = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t          state;
  logic            op_q;
  logic [RIW-1:0]  sidx_q;
  logic            slive_q;
  logic [DW-1:0]   sval_q;
  logic [AW-1:0]  addr_q;
  logic            reject_q;

  logic live_s, live_a, live_b;
  assign live_s = (src_idx    != '0) && (32'(src_idx)    < NREGS);
  assign live_a = (base_a_idx != '0) && (32'(base_a_idx) < NREGS);
  assign live_b = (base_b_idx != '0) && (32'(base_b_idx) < NREGS);

  assign rf_raddr_s = src_idx;
  assign rf_raddr_a = base_a_idx;
  assign rf_raddr_b = base_b_idx;

  logic [DW-1:0] ea_full;
  assign ea_full = disp + (live_a ? rf_rdata_a : '0) + (live_b ? rf_rdata_b : '0);

  logic unused_ea_hi;
  assign unused_ea_hi = ^ea_full[DW-1:AW];

  logic accept, legal;
  assign accept = start && (state == S_IDLE);
  assign legal  = (src_kind == KIND_REG) && (dst_kind == KIND_MEM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= 1'b0;
      sidx_q   <= '0;
      slive_q  <= 1'b0;
      sval_q   <= '0;
      addr_q   <= '0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= accept && !legal;
      case (state)
        S_IDLE: if (accept && legal) begin
          state   <= S_READ;
          op_q    <= op;
          sidx_q  <= src_idx;
          slive_q <= live_s;
          sval_q  <= live_s ? rf_rdata_s : '0;
          addr_q  <= ea_full[AW-1:0];
        end
        S_READ:  state <= S_WRITE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_en    = (state != S_IDLE);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = op_q ? (mem_rdata + sval_q) : sval_q;
  assign rf_we     = (state == S_WRITE) && slive_q;
  assign rf_waddr  = sidx_q;
  assign rf_wdata  = mem_rdata;
  assign lock      = mem_en;
  assign busy      = mem_en;
  assign done      = (state == S_WRITE);
  assign reject    = reject_q;

  // R7: a read is always followed by a locked write to the same word
  a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_we && lock && mem_addr == $past(mem_addr)));

  // R7: done only comes right after a read cycle
  a_r7_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_en && !mem_we));

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: no writes into the hidden zero register or unused indices
  a_r5_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0 && 32'(rf_waddr) < NREGS));

  // R6: an illegal request never starts a memory access
  a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!mem_en && !rf_we && !$past(busy)));

  // R8: a start during an operation does not extend or restart it
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_we) |=> !busy);

  // R6: legal start while idle begins an access
  a_r6_legal_go: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && src_kind == KIND_REG && dst_kind == KIND_MEM) |=> (busy && !mem_we));
endmodule

// File: tb/rmw_lock_unit_bench.sv
module rmw_lock_unit_bench;
  localparam int DW = 32, AW = 10, RIW = 3, NREGS = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0, op = 1'b0;
  logic [1:0] src_kind = 2'd0, dst_kind = 2'd2;
  logic [RIW-1:0] src_idx = '0, base_a_idx = '0, base_b_idx = '0;
  logic [DW-1:0] disp = '0;
  logic [RIW-1:0] rf_raddr_s, rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [DW-1:0] rf_rdata_s, rf_rdata_a, rf_rdata_b, rf_wdata;
  logic rf_we, mem_en, mem_we, lock, busy, done, reject;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] rf [0:7];
  logic [DW-1:0] mem [0:DEPTH-1];

  assign rf_rdata_s = rf[rf_raddr_s];
  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  rmw_lock_unit #(.DW(DW), .AW(AW), .RIW(RIW), .NREGS(NREGS)) u_rmw_lock_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_kind(src_kind),
    .dst_kind(dst_kind), .src_idx(src_idx), .base_a_idx(base_a_idx),
    .base_b_idx(base_b_idx), .disp(disp), .rf_raddr_s(rf_raddr_s),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b), .rf_rdata_s(rf_rdata_s),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .lock(lock), .busy(busy), .done(done), .reject(reject));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rval(input logic [RIW-1:0] idx);
    return (idx == 0 || int'(idx) >= NREGS) ? '0 : rf[idx];
  endfunction

  function automatic logic [AW-1:0] ea_of(input logic [DW-1:0] d, input logic [RIW-1:0] a, input logic [RIW-1:0] b);
    logic [DW-1:0] s;
    s = d + rval(a) + rval(b);
    return s[AW-1:0];
  endfunction

  task automatic do_op(input logic o, input logic [1:0] sk, input logic [1:0] dk,
                       input logic [RIW-1:0] s, input logic [RIW-1:0] a,
                       input logic [RIW-1:0] b, input logic [DW-1:0] d, input bit poke);
    logic [AW-1:0] ea, pea;
    logic [DW-1:0] old, sv, newm, srf_before, pmem;
    bit legal, slive;
    legal = (sk == 2'd0) && (dk == 2'd2);
    slive = (s != 0) && (int'(s) < NREGS);
    ea = ea_of(d, a, b);
    old = mem[ea];
    sv = rval(s);
    newm = o ? old + sv : sv;
    srf_before = rf[s];
    pea = ea + 10'd5;
    pmem = mem[pea];
    @(negedge clk);
    op = o; src_kind = sk; dst_kind = dk; src_idx = s;
    base_a_idx = a; base_b_idx = b; disp = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!legal) begin
      chk(reject == 1'b1, "R6 reject pulse", {31'b0, reject}, 1);
      chk(!busy && !mem_en, "R6 no access", {31'b0, busy}, 0);
      @(negedge clk);
      chk(reject == 1'b0, "R6 reject one cycle", {31'b0, reject}, 0);
      chk(mem[ea] == old, "R6 memory untouched", mem[ea], old);
      chk(rf[s] == srf_before, "R6 register untouched", rf[s], srf_before);
      return;
    end
    chk(busy && lock && mem_en && !mem_we, "R7 read cycle", {28'b0, busy, lock, mem_en, mem_we}, 32'hE);
    chk(mem_addr == ea, "R1 address", {22'b0, mem_addr}, {22'b0, ea});
    chk(reject == 1'b0, "R6 no reject when legal", {31'b0, reject}, 0);
    if (poke) begin
      op = ~o; src_idx = 3'd4; base_a_idx = 3'd0; base_b_idx = 3'd0;
      disp = {22'b0, pea}; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done && mem_we && lock, "R7 write cycle", {29'b0, done, mem_we, lock}, 7);
    chk(rf_we == slive, "R5 writeback enable", {31'b0, rf_we}, {31'b0, slive});
    chk(mem_wdata == newm, o ? "R4 fetch-add data" : "R3 exchange data", mem_wdata, newm);
    chk(rf_wdata == old, o ? "R4 old word to register" : "R3 old word to register", rf_wdata, old);
    @(negedge clk);
    chk(!busy && !done && !lock, "R7 idle after", {29'b0, busy, done, lock}, 0);
    chk(mem[ea] == newm, o ? "R4 memory result" : "R3 memory result", mem[ea], newm);
    if (slive) chk(rf[s] == old, "R3 register result", rf[s], old);
    else       chk(rf[s] == srf_before, "R5 zero register unchanged", rf[s], srf_before);
    if (poke) begin
      chk(mem[pea] == pmem, "R8 start while busy ignored", mem[pea], pmem);
      @(negedge clk);
      chk(!busy, "R8 no second operation", {31'b0, busy}, 0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
    rf[0] = 32'hDEAD_BEEF; rf[7] = 32'hCAFE_F00D;
    for (int i = 1; i < 7; i++) rf[i] = 32'd16 * i;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !lock && !mem_en && !mem_we && !rf_we && !reject, "R9 reset state",
        {25'b0, busy, done, lock, mem_en, mem_we, rf_we, reject}, 0);
    rst_n = 1'b1;

    do_op(1'b0, 2'd0, 2'd2, 3'd1, 3'd0, 3'd0, 32'd40, 0);              // R2 direct address
    do_op(1'b1, 2'd0, 2'd2, 3'd2, 3'd3, 3'd4, 32'hFFFF_FFF0, 0);       // R1 negative displacement
    rf[5] = 32'hFFFF_FFFF; mem[7] = 32'hFFFF_FFFF; rf[1] = 32'd1;
    do_op(1'b1, 2'd0, 2'd2, 3'd1, 3'd5, 3'd0, 32'd8, 0);               // R4 wrap of sum and of data
    do_op(1'b0, 2'd0, 2'd2, 3'd0, 3'd2, 3'd0, 32'd3, 0);               // R5 source is zero register
    do_op(1'b1, 2'd0, 2'd2, 3'd7, 3'd7, 3'd1, 32'd9, 0);               // R2 index 7 reads zero
    do_op(1'b0, 2'd0, 2'd2, 3'd3, 3'd3, 3'd3, 32'd0, 0);               // source also address term
    do_op(1'b0, 2'd1, 2'd2, 3'd1, 3'd0, 3'd0, 32'd12, 0);              // R6 immediate source
    do_op(1'b1, 2'd0, 2'd0, 3'd1, 3'd0, 3'd0, 32'd12, 0);              // R6 register destination
    do_op(1'b0, 2'd0, 2'd2, 3'd6, 3'd1, 3'd2, 32'd100, 1);             // R8 poke during read
    do_op(1'b1, 2'd0, 2'd2, 3'd2, 3'd0, 3'd1, 32'd200, 1);             // R8 poke during read

    for (int i = 0; i < 200; i++) begin
      logic [1:0] sk, dk;
      if (i % 20 == 0) for (int r = 1; r < 7; r++) rf[r] = $urandom;
      sk = ($urandom % 8 == 0) ? 2'($urandom) : 2'd0;
      dk = ($urandom % 8 == 0) ? 2'($urandom) : 2'd2;
      do_op(1'($urandom), sk, dk, 3'($urandom), 3'($urandom), 3'($urandom),
            32'($signed($urandom % 2048) - 1024), ($urandom % 10 == 0));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule